// File: doc/BRIEF.md
# Sequential Two-Read Two-Write Register File

This block behaves as a register file with two read ports and two write ports, but it stores its words in a single RAM. That RAM has one read port and one write port. A small phase sequencer splits each model cycle into three fast-clock cycles. The block gives up throughput in exchange for far less storage logic and a shorter critical path.

A model cycle begins when `start` is high while the sequencer is idle. On that edge the block takes both read addresses and both write address/data pairs. Two edges later the two read values are ready. On the following cycle `done` pulses for one cycle and the outputs take the new values. To the user, a read costs zero model cycles: each read returns the contents as they stood before that model cycle's own writes. Register contents are not cleared by reset.

Top module: `seqport_regfile`

## Requirements
- R1: While `rst_n` is low, and in the cycle after it is released, `done` is 0 and both read outputs are 0.
- R2: A `start` seen high on a rising edge while idle is accepted. `done` is then high only in the cycle after the third rising edge counted from the accepting edge, so one model cycle costs three fast cycles.
- R3: Each read output holds the word at its address as it was before the same model cycle's writes, including when that address is also written in that model cycle.
- R4: Both write ports store their data, and the new words are returned by reads in any later model cycle.
- R5: When both write ports name the same address in one model cycle, the word from write port B is the one kept.
- R6: A `start` that is high during the two cycles after an accepted edge is ignored. It produces no extra `done` pulse, and its write data is not stored.
- R7: Between `done` pulses, both read outputs stay constant whatever the inputs do.
- R8: The two read ports are independent and may name the same address; each returns the correct word.
- R9: A `start` that is high in the same cycle as `done` is accepted, so model cycles can run back to back every three fast cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast clock |
| rst_n | input | 1 | Active-low synchronous reset of the sequencer and outputs |
| start | input | 1 | Begin a model cycle (taken only when idle) |
| rd_addr_a | input | ADDR_W | Read port A address |
| rd_addr_b | input | ADDR_W | Read port B address |
| wr_addr_a | input | ADDR_W | Write port A address |
| wr_data_a | input | DATA_W | Write port A data |
| wr_addr_b | input | ADDR_W | Write port B address |
| wr_data_b | input | DATA_W | Write port B data |
| rd_data_a | output | DATA_W | Read port A result of the last model cycle |
| rd_data_b | output | DATA_W | Read port B result of the last model cycle |
| done | output | 1 | One-cycle pulse marking the end of a model cycle |

## Verification
The hardest case to reach is the fast cycle where the RAM reads the port B address while writing port A to that same address. The read must still return the old word. Only table vectors whose read B address equals their write A address reach that collision. A bench-side array model with true multi-port semantics checks that the old word comes back. A second hard case is a `start` held high into the busy phases with junk write data. A directed test drives it and then reads the target address in a later model cycle to show that nothing was stored.

// File: rtl/seqrf_pkg.sv
package seqrf_pkg;

    // Phase of the sequencer inside one model cycle.
    //   PH_IDLE : waiting; on start the RAM reads port A's address
    //   PH_WR_A : RAM reads port B's address and stores write port A
    //   PH_WR_B : RAM stores write port B; results are registered
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_WR_A = 2'd1,
        PH_WR_B = 2'd2
    } phase_e;

endpackage

// File: rtl/seqrf_ram.sv
module seqrf_ram #(
    parameter int ADDR_W = 5,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    // Read-first: a read and a write to one address on the same edge
    // return the old word.
    always_ff @(posedge clk) begin
        rdata <= mem[raddr];
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

endmodule

// File: rtl/seqrf_ctrl.sv
module seqrf_ctrl
    import seqrf_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] rd_addr_a_i,
    input  logic [ADDR_W-1:0] rd_addr_b_i,
    input  logic [ADDR_W-1:0] wr_addr_a_i,
    input  logic [DATA_W-1:0] wr_data_a_i,
    input  logic [ADDR_W-1:0] wr_addr_b_i,
    input  logic [DATA_W-1:0] wr_data_b_i,
    output logic [ADDR_W-1:0] ram_raddr_o,
    input  logic [DATA_W-1:0] ram_rdata_i,
    output logic              ram_we_o,
    output logic [ADDR_W-1:0] ram_waddr_o,
    output logic [DATA_W-1:0] ram_wdata_o,
    output logic [DATA_W-1:0] rd_data_a_o,
    output logic [DATA_W-1:0] rd_data_b_o,
    output logic              done_o
);

    typedef struct packed {
        phase_e            phase;
        logic [ADDR_W-1:0] rb_addr;
        logic [ADDR_W-1:0] wa_addr;
        logic [DATA_W-1:0] wa_data;
        logic [ADDR_W-1:0] wb_addr;
        logic [DATA_W-1:0] wb_data;
        logic [DATA_W-1:0] stage_a;
        logic [DATA_W-1:0] out_a;
        logic [DATA_W-1:0] out_b;
        logic              done;
    } ctrl_state_t;

    ctrl_state_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.done   = 1'b0;
        ram_raddr_o = rd_addr_a_i;
        ram_we_o    = 1'b0;
        ram_waddr_o = st_q.wa_addr;
        ram_wdata_o = st_q.wa_data;

        unique case (st_q.phase)
            PH_IDLE: begin
                if (start_i) begin
                    st_d.rb_addr = rd_addr_b_i;
                    st_d.wa_addr = wr_addr_a_i;
                    st_d.wa_data = wr_data_a_i;
                    st_d.wb_addr = wr_addr_b_i;
                    st_d.wb_data = wr_data_b_i;
                    st_d.phase   = PH_WR_A;
                end
            end
            PH_WR_A: begin
                ram_raddr_o  = st_q.rb_addr;
                ram_we_o     = 1'b1;
                st_d.stage_a = ram_rdata_i;
                st_d.phase   = PH_WR_B;
            end
            PH_WR_B: begin
                ram_we_o    = 1'b1;
                ram_waddr_o = st_q.wb_addr;
                ram_wdata_o = st_q.wb_data;
                st_d.out_a  = st_q.stage_a;
                st_d.out_b  = ram_rdata_i;
                st_d.done   = 1'b1;
                st_d.phase  = PH_IDLE;
            end
            default: begin
                st_d.phase = PH_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_data_a_o = st_q.out_a;
    assign rd_data_b_o = st_q.out_b;
    assign done_o      = st_q.done;

endmodule

// File: rtl/seqport_regfile.sv
module seqport_regfile #(
    parameter int ADDR_W = 5,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] rd_addr_a,
    input  logic [ADDR_W-1:0] rd_addr_b,
    input  logic [ADDR_W-1:0] wr_addr_a,
    input  logic [DATA_W-1:0] wr_data_a,
    input  logic [ADDR_W-1:0] wr_addr_b,
    input  logic [DATA_W-1:0] wr_data_b,
    output logic [DATA_W-1:0] rd_data_a,
    output logic [DATA_W-1:0] rd_data_b,
    output logic              done
);

    logic [ADDR_W-1:0] ram_raddr;
    logic [DATA_W-1:0] ram_rdata;
    logic              ram_we;
    logic [ADDR_W-1:0] ram_waddr;
    logic [DATA_W-1:0] ram_wdata;

    seqrf_ctrl #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start),
        .rd_addr_a_i(rd_addr_a),
        .rd_addr_b_i(rd_addr_b),
        .wr_addr_a_i(wr_addr_a),
        .wr_data_a_i(wr_data_a),
        .wr_addr_b_i(wr_addr_b),
        .wr_data_b_i(wr_data_b),
        .ram_raddr_o(ram_raddr),
        .ram_rdata_i(ram_rdata),
        .ram_we_o   (ram_we),
        .ram_waddr_o(ram_waddr),
        .ram_wdata_o(ram_wdata),
        .rd_data_a_o(rd_data_a),
        .rd_data_b_o(rd_data_b),
        .done_o     (done)
    );

    seqrf_ram #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W)
    ) u_ram (
        .clk  (clk),
        .raddr(ram_raddr),
        .rdata(ram_rdata),
        .we   (ram_we),
        .waddr(ram_waddr),
        .wdata(ram_wdata)
    );

endmodule

// File: rtl/seqrf_chk.sv
module seqrf_chk #(
    parameter int ADDR_W = 5,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              done,
    input logic [DATA_W-1:0] rd_data_a,
    input logic [DATA_W-1:0] rd_data_b
);
    // Shadow count of busy cycles left, rebuilt from the ports only.
    logic [1:0] pend_q;
    logic       accept;

    assign accept = start && (pend_q == 2'd0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 2'd0;
        end else if (accept) begin
            pend_q <= 2'd2;
        end else if (pend_q != 2'd0) begin
            pend_q <= pend_q - 2'd1;
        end
    end

    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (!done && rd_data_a == '0 && rd_data_b == '0));

    a_r2_done_latency: assert property (@(posedge clk) disable iff (!rst_n)
        accept |-> ##3 done);

    a_r2_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r6_no_done_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q != 2'd0) |-> !done);

    a_r7_hold_outputs: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(rd_data_a) && $stable(rd_data_b)));

endmodule

bind seqport_regfile seqrf_chk #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .done     (done),
    .rd_data_a(rd_data_a),
    .rd_data_b(rd_data_b)
);

// File: tb/seqport_regfile_tb.sv
module seqport_regfile_tb;

    localparam int AW = 5;
    localparam int DW = 32;
    localparam int NV = 12;

    typedef struct packed {
        logic [AW-1:0] ra;
        logic [AW-1:0] rb;
        logic [AW-1:0] wa1;
        logic [DW-1:0] wd1;
        logic [AW-1:0] wa2;
        logic [DW-1:0] wd2;
    } vec_t;

    // Stimulus vectors; expected reads come from the array model.
    localparam vec_t VECS [NV] = '{
        '{5'd1,  5'd2,  5'd3,  32'hDEAD0003, 5'd4,  32'hBEEF0004},
        '{5'd3,  5'd4,  5'd1,  32'h11110001, 5'd2,  32'h22220002},
        '{5'd5,  5'd6,  5'd5,  32'hA5A5A5A5, 5'd9,  32'h5A5A5A5A},
        '{5'd7,  5'd8,  5'd10, 32'h0000FFFF, 5'd8,  32'hFFFF0000},
        '{5'd0,  5'd31, 5'd0,  32'h00000000, 5'd31, 32'hFFFFFFFF},
        '{5'd0,  5'd31, 5'd12, 32'h0C0C0C0C, 5'd13, 32'h0D0D0D0D},
        '{5'd9,  5'd9,  5'd14, 32'h0E0E0E0E, 5'd15, 32'h0F0F0F0F},
        '{5'd20, 5'd21, 5'd21, 32'h21212121, 5'd20, 32'h20202020},
        '{5'd20, 5'd21, 5'd22, 32'h22222222, 5'd22, 32'h33333333},
        '{5'd22, 5'd5,  5'd5,  32'h55555555, 5'd5,  32'h66666666},
        '{5'd5,  5'd22, 5'd16, 32'h16161616, 5'd17, 32'h17171717},
        '{5'd16, 5'd17, 5'd16, 32'h99999999, 5'd17, 32'h88888888}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [AW-1:0] rd_addr_a = '0;
    logic [AW-1:0] rd_addr_b = '0;
    logic [AW-1:0] wr_addr_a = '0;
    logic [DW-1:0] wr_data_a = '0;
    logic [AW-1:0] wr_addr_b = '0;
    logic [DW-1:0] wr_data_b = '0;
    logic [DW-1:0] rd_data_a;
    logic [DW-1:0] rd_data_b;
    logic          done;

    logic [DW-1:0] model [32];
    int n_chk = 0;
    int n_err = 0;

    always #4 clk = ~clk;

    seqport_regfile #(.ADDR_W(AW), .DATA_W(DW)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .rd_addr_a(rd_addr_a), .rd_addr_b(rd_addr_b),
        .wr_addr_a(wr_addr_a), .wr_data_a(wr_data_a),
        .wr_addr_b(wr_addr_b), .wr_data_b(wr_data_b),
        .rd_data_a(rd_data_a), .rd_data_b(rd_data_b), .done(done)
    );

    task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Called at a negedge; returns at the negedge where done is expected.
    task automatic run_op(input logic [AW-1:0] ra, input logic [AW-1:0] rb,
                          input logic [AW-1:0] wa1, input logic [DW-1:0] wd1,
                          input logic [AW-1:0] wa2, input logic [DW-1:0] wd2,
                          input bit chk_rd, input bit busy_start, input string tag);
        logic [DW-1:0] exp_a;
        logic [DW-1:0] exp_b;
        logic [2:0]    dpat;
        exp_a = model[ra];
        exp_b = model[rb];
        rd_addr_a = ra; rd_addr_b = rb;
        wr_addr_a = wa1; wr_data_a = wd1;
        wr_addr_b = wa2; wr_data_b = wd2;
        start = 1'b1;
        @(negedge clk);
        dpat[2] = done;
        start = busy_start;
        wr_data_a = ~wd1; wr_data_b = ~wd2;
        rd_addr_a = ~ra; rd_addr_b = ~rb;
        @(negedge clk);
        dpat[1] = done;
        start = 1'b0;
        @(negedge clk);
        dpat[0] = done;
        check({tag, " R2 done timing"}, {29'd0, dpat}, 32'd1);
        if (chk_rd) begin
            check({tag, " R3 read A"}, rd_data_a, exp_a);
            check({tag, " R3 read B"}, rd_data_b, exp_b);
        end
        model[wa1] = wd1;
        model[wa2] = wd2;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog R2: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 done in reset", {31'd0, done}, 32'd0);
        check("R1 rd_data_a in reset", rd_data_a, '0);
        check("R1 rd_data_b in reset", rd_data_b, '0);
        rst_n = 1'b1;

        // Fill every entry; reads are not checked (contents not reset). R4
        for (int i = 0; i < 16; i++) begin
            run_op(AW'(0), AW'(0), AW'(2*i), 32'h1000_0000 + 32'(2*i) * 32'h0101_0101,
                   AW'(2*i+1), 32'h1000_0000 + 32'(2*i+1) * 32'h0101_0101, 1'b0, 1'b0, "fill");
        end
        // Back-to-back start in the done cycle, R9, and read-back of the fill, R4
        for (int i = 0; i < 16; i++) begin
            run_op(AW'(2*i), AW'(2*i+1), AW'(2*i), model[2*i], AW'(2*i+1), model[2*i+1],
                   1'b1, 1'b0, "R4 R9 readback");
        end
        // Table walk: read-before-write R3, same-address writes R5, shared read address R8
        for (int v = 0; v < NV; v++) begin
            run_op(VECS[v].ra, VECS[v].rb, VECS[v].wa1, VECS[v].wd1,
                   VECS[v].wa2, VECS[v].wd2, 1'b1, 1'b0, $sformatf("vec%0d R5 R8", v));
        end

        // R5: directed same-address writes, then read back
        run_op(AW'(1), AW'(2), AW'(7), 32'hAAAA0007, AW'(7), 32'hBBBB0007, 1'b1, 1'b0, "R5 setup");
        run_op(AW'(7), AW'(7), AW'(3), model[3], AW'(4), model[4], 1'b1, 1'b0, "R5 R8 readback");
        check("R5 port B wins", rd_data_a, 32'hBBBB0007);

        // R6: start held high while busy with altered write data
        run_op(AW'(11), AW'(12), AW'(11), 32'h61616161, AW'(12), 32'h62626262, 1'b1, 1'b1, "R6 busy");
        @(negedge clk);
        check("R6 no extra done", {31'd0, done}, 32'd0);
        run_op(AW'(11), AW'(12), AW'(0), model[0], AW'(1), model[1], 1'b1, 1'b0, "R6 readback");
        check("R6 ignored write A", rd_data_a, 32'h61616161);
        check("R6 ignored write B", rd_data_b, 32'h62626262);

        // R7: outputs hold while inputs wander without start
        begin
            logic [DW-1:0] ha;
            logic [DW-1:0] hb;
            ha = rd_data_a; hb = rd_data_b;
            for (int k = 0; k < 6; k++) begin
                @(negedge clk);
                rd_addr_a = AW'(k); rd_addr_b = AW'(31 - k);
                wr_addr_a = AW'(k); wr_data_a = 32'(k) * 32'h1357_9BDF;
            end
            @(negedge clk);
            check("R7 hold A", rd_data_a, ha);
            check("R7 hold B", rd_data_b, hb);
            check("R7 no done", {31'd0, done}, 32'd0);
        end

        // R1: reset in mid model cycle (writes leave contents unchanged)
        rd_addr_a = AW'(3); rd_addr_b = AW'(4);
        wr_addr_a = AW'(3); wr_data_a = model[3];
        wr_addr_b = AW'(4); wr_data_b = model[4];
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 done after mid reset", {31'd0, done}, 32'd0);
        check("R1 rd_data_a after mid reset", rd_data_a, '0);
        check("R1 rd_data_b after mid reset", rd_data_b, '0);
        run_op(AW'(3), AW'(4), AW'(5), 32'hC0DE0005, AW'(6), 32'hC0DE0006, 1'b1, 1'b0, "R2 after reset");
        run_op(AW'(5), AW'(6), AW'(5), model[5], AW'(6), model[6], 1'b1, 1'b0, "R4 final");

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule